// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block counts processor events on two 32-bit counters, named upper and lower, that share one control word. The core presents one pulse per cycle on each line of an event vector. Each counter has a 12-bit select field in the control word. A table fixed by parameters maps each supported select code to one line of the event vector. A counter steps by one when its selected line is high and the privilege context the core reports is enabled in the control word.

There is one set of context enables for both counters, so neither counter can be started or stopped on its own. Software parks an idle counter by selecting code 0x220. No table entry may hold that code, so the parked counter never moves. When a counter wraps from all-ones to zero, it sets a sticky overflow flag. The flag raises the interrupt output if that counter's interrupt enable is on.

Software reaches the block through a simple register port with 64-bit data. There are three registers: the control word, the packed counter pair, and the overflow flags.

Top module: `perfmon_dual`

## Requirements
- R1: After reset, the control word, both counters and both overflow flags read as zero, and `irq` is low.
- R2: Address 1 reads the counter pair as {upper[31:0], lower[31:0]}. A write to address 1 loads both counters in the same cycle.
- R3: Address 0 is the control word, with these fields:
  - bit 1: supervisor enable
  - bit 2: user enable
  - bit 3: hypervisor enable
  - bit 4: lower interrupt enable
  - bit 5: upper interrupt enable
  - bits 17:6: lower event select
  - bits 30:19: upper event select

  Bits 0 and 18, and bits 63:31, read as zero whatever was written (a write of all ones reads back 0x7FFBFFFE).
- R4: Each counter adds one in every cycle in which the event line mapped to its own select code is high and the context is enabled. The default table maps these codes to event lines 0 to 7, in order: 0x2FF, 0x208, 0x302, 0x201, 0x202, 0x210, 0x301, 0x330. Each counter decodes its select independently of the other.
- R5: A select code that is not in the table, including the parking code 0x220, never counts, whatever the event lines carry.
- R6: The `priv_level` input encodes the context as 0 user, 1 supervisor, 2 hypervisor and 3 none. Counting is allowed only while the enable bit for the current context is set. Context 3 never counts.
- R7: With all three context enables clear, neither counter changes except by a register write.
- R8: A counter that steps from 0xFFFFFFFF reads 0 on the next cycle and sets its own overflow flag. The flag stays set through later counting.
- R9: Address 2 returns the lower flag in bit 0 and the upper flag in bit 1. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly while a flag is set whose interrupt enable (bit 4 for lower, bit 5 for upper) is on.
- R11: When a counter write and an increment fall in the same cycle, the written value wins: no increment is applied and no overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 control, 1 counters, 2 flags |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| priv_level | input | 2 | Current privilege context |
| event_pulse | input | NUM_EVT | One pulse per cycle for each event source |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest states to reach from the ports are a counter wrapping and a write landing in the same cycle as an increment. Only a preload through the packed counter register can bring a counter to the edge of wrap in a few cycles. The stimulus therefore preloads values just below the wrap, pulses the selected event, and holds an event pulse high while the write lands. The select and context behaviour is swept over every pair of table entries and every combination of enables and privilege level.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

   // event select field width and control word positions
   localparam int SEL_W      = 12;
   localparam int SUP_BIT    = 1;
   localparam int USR_BIT    = 2;
   localparam int HYP_BIT    = 3;
   localparam int IRQ_LO_BIT = 4;
   localparam int IRQ_HI_BIT = 5;
   localparam int LO_SEL_LSB = 6;
   localparam int HI_SEL_LSB = 19;
   localparam int CTRL_W     = HI_SEL_LSB + SEL_W;

   // code reserved for parking an idle counter
   localparam logic [SEL_W-1:0] PARK_CODE = 12'h220;

   // counter slots
   localparam int SLOT_LO  = 0;
   localparam int SLOT_HI  = 1;
   localparam int N_SLOTS  = 2;

   typedef enum logic [1:0] {
      PRIV_USER  = 2'd0,
      PRIV_SUPER = 2'd1,
      PRIV_HYPER = 2'd2,
      PRIV_NONE  = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_CNT  = 2'd1,
      REG_FLAG = 2'd2,
      REG_NONE = 2'd3
   } reg_e;

   function automatic logic [CTRL_W-1:0] ctrl_mask();
      logic [CTRL_W-1:0] m;
      m = '0;
      m[SUP_BIT]    = 1'b1;
      m[USR_BIT]    = 1'b1;
      m[HYP_BIT]    = 1'b1;
      m[IRQ_LO_BIT] = 1'b1;
      m[IRQ_HI_BIT] = 1'b1;
      m[LO_SEL_LSB +: SEL_W] = '1;
      m[HI_SEL_LSB +: SEL_W] = '1;
      return m;
   endfunction

   localparam logic [CTRL_W-1:0] CTRL_MASK = ctrl_mask();

endpackage

// File: rtl/perfmon_evt_decode.sv
module perfmon_evt_decode
   import perfmon_pkg::*;
#(
   parameter int                         NUM_EVT   = 8,
   parameter logic [NUM_EVT*SEL_W-1:0]   EVT_CODES = '0
)(
   input  logic [SEL_W-1:0]   sel,
   input  logic [NUM_EVT-1:0] pulses,
   output logic               hit
);

   logic [NUM_EVT-1:0] match;

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_entry
      localparam logic [SEL_W-1:0] CODE = EVT_CODES[i*SEL_W +: SEL_W];
      assign match[i] = (sel == CODE) && pulses[i];
   end

   assign hit = |match;

endmodule

// File: rtl/perfmon_ctr.sv
module perfmon_ctr #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         clr,
   output logic [W-1:0] count,
   output logic         flag
);

   logic wrap;

   // a load suppresses both the step and the wrap it would cause
   assign wrap = inc && !load && (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (inc) begin
         count <= count + 1'b1;
      end
   end

   // set dominates clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (wrap) begin
         flag <= 1'b1;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end

endmodule

// File: rtl/perfmon_dual.sv
module perfmon_dual
   import perfmon_pkg::*;
#(
   parameter int                       CTR_W     = 32,
   parameter int                       BUS_AW    = 2,
   parameter int                       NUM_EVT   = 8,
   parameter logic [NUM_EVT*SEL_W-1:0] EVT_CODES = {
      12'h330, 12'h301, 12'h210, 12'h202,
      12'h201, 12'h302, 12'h208, 12'h2FF
   }
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [BUS_AW-1:0]    bus_addr,
   input  logic [2*CTR_W-1:0]   bus_wdata,
   output logic [2*CTR_W-1:0]   bus_rdata,
   input  logic [1:0]           priv_level,
   input  logic [NUM_EVT-1:0]   event_pulse,
   output logic                 irq
);

   localparam int DATA_W = 2 * CTR_W;

   localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(REG_CTRL);
   localparam logic [BUS_AW-1:0] A_CNT  = BUS_AW'(REG_CNT);
   localparam logic [BUS_AW-1:0] A_FLAG = BUS_AW'(REG_FLAG);

   function automatic bit codes_avoid_park(input logic [NUM_EVT*SEL_W-1:0] tbl);
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < NUM_EVT; i++) begin
         if (tbl[i*SEL_W +: SEL_W] == PARK_CODE) ok = 1'b0;
      end
      return ok;
   endfunction

   // elaboration checks
   if (NUM_EVT < 1) begin : g_bad_evt
      $error("perfmon_dual: NUM_EVT must be at least 1");
   end
   if (BUS_AW < 2) begin : g_bad_aw
      $error("perfmon_dual: BUS_AW must be at least 2");
   end
   if (CTRL_W > DATA_W) begin : g_bad_w
      $error("perfmon_dual: CTR_W too small to hold the control word");
   end
   if (!codes_avoid_park(EVT_CODES)) begin : g_bad_tbl
      $error("perfmon_dual: event table must not contain the parking code");
   end

   logic                         wr_ctrl;
   logic                         wr_cnt;
   logic                         wr_flag;
   logic [CTRL_W-1:0]            ctrl_q;
   logic                         ctx_ok;
   logic [N_SLOTS-1:0]           inc;
   logic [N_SLOTS-1:0]           clr;
   logic [N_SLOTS-1:0]           flag_q;
   logic [N_SLOTS-1:0]           irq_src;
   logic [N_SLOTS-1:0][CTR_W-1:0] cnt_q;

   assign wr_ctrl = bus_valid && bus_write && (bus_addr == A_CTRL);
   assign wr_cnt  = bus_valid && bus_write && (bus_addr == A_CNT);
   assign wr_flag = bus_valid && bus_write && (bus_addr == A_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_MASK;
      end
   end

   // context gate shared by both counters
   always_comb begin
      case (priv_e'(priv_level))
         PRIV_USER:  ctx_ok = ctrl_q[USR_BIT];
         PRIV_SUPER: ctx_ok = ctrl_q[SUP_BIT];
         PRIV_HYPER: ctx_ok = ctrl_q[HYP_BIT];
         default:    ctx_ok = 1'b0;
      endcase
   end

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      localparam int SEL_LSB = (g == SLOT_HI) ? HI_SEL_LSB : LO_SEL_LSB;
      localparam int IEN_BIT = (g == SLOT_HI) ? IRQ_HI_BIT : IRQ_LO_BIT;
      logic hit;

      perfmon_evt_decode #(
         .NUM_EVT   (NUM_EVT),
         .EVT_CODES (EVT_CODES)
      ) u_dec (
         .sel    (ctrl_q[SEL_LSB +: SEL_W]),
         .pulses (event_pulse),
         .hit    (hit)
      );

      assign inc[g] = hit && ctx_ok;
      assign clr[g] = wr_flag && bus_wdata[g];

      perfmon_ctr #(
         .W (CTR_W)
      ) u_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc      (inc[g]),
         .load     (wr_cnt),
         .load_val (bus_wdata[g*CTR_W +: CTR_W]),
         .clr      (clr[g]),
         .count    (cnt_q[g]),
         .flag     (flag_q[g])
      );

      assign irq_src[g] = flag_q[g] && ctrl_q[IEN_BIT];
   end

   assign irq = |irq_src;

   always_comb begin
      case (bus_addr)
         A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
         A_CNT:   bus_rdata = {cnt_q[SLOT_HI], cnt_q[SLOT_LO]};
         A_FLAG:  bus_rdata = DATA_W'(flag_q);
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/perfmon_dual_chk.sv
module perfmon_dual_chk
   import perfmon_pkg::*;
#(
   parameter int CTR_W = 32
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [CTRL_W-1:0]              ctrl,
   input  logic [N_SLOTS-1:0][CTR_W-1:0]  cnt,
   input  logic [N_SLOTS-1:0]             flag,
   input  logic [N_SLOTS-1:0]             inc,
   input  logic [N_SLOTS-1:0]             clr,
   input  logic                           wr_cnt,
   input  logic [2*CTR_W-1:0]             wdata,
   input  logic                           irq
);

   // R8
   wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_cnt && inc[SLOT_LO] && (&cnt[SLOT_LO])) |=> (flag[SLOT_LO] && cnt[SLOT_LO] == '0));

   // R8
   wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_cnt && inc[SLOT_HI] && (&cnt[SLOT_HI])) |=> (flag[SLOT_HI] && cnt[SLOT_HI] == '0));

   // R11
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> ({cnt[SLOT_HI], cnt[SLOT_LO]} == $past(wdata)));

   // R7
   ctx_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_cnt && ctrl[HYP_BIT:SUP_BIT] == '0) |=> $stable(cnt));

   // R9
   clear_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[SLOT_LO] && !(inc[SLOT_LO] && !wr_cnt && (&cnt[SLOT_LO]))) |=> !flag[SLOT_LO]);

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag == '0) |-> !irq);

   // R10
   irq_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[SLOT_LO] && ctrl[IRQ_LO_BIT]) |-> irq);

endmodule

bind perfmon_dual perfmon_dual_chk #(.CTR_W(CTR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ctrl   (ctrl_q),
   .cnt    (cnt_q),
   .flag   (flag_q),
   .inc    (inc),
   .clr    (clr),
   .wr_cnt (wr_cnt),
   .wdata  (bus_wdata),
   .irq    (irq)
);

// File: tb/perfmon_dual_bench.sv
module perfmon_dual_bench;

   localparam int NE = 8;
   localparam logic [11:0] CODES [NE] = '{12'h2FF, 12'h208, 12'h302, 12'h201,
                                          12'h202, 12'h210, 12'h301, 12'h330};

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_valid;
   logic        bus_write;
   logic [1:0]  bus_addr;
   logic [63:0] bus_wdata;
   logic [63:0] bus_rdata;
   logic [1:0]  priv_level;
   logic [NE-1:0] event_pulse;
   logic        irq;

   int n_run  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   perfmon_dual u_perfmon_dual (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_valid   (bus_valid),
      .bus_write   (bus_write),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .priv_level  (priv_level),
      .event_pulse (event_pulse),
      .irq         (irq)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [63:0] d);
      bus_valid = 1'b1;
      bus_write = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      tick();
      bus_valid = 1'b0;
      bus_write = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [63:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(input logic [NE-1:0] m, input int cycles);
      event_pulse = m;
      repeat (cycles) tick();
      event_pulse = '0;
   endtask

   function automatic logic [63:0] mk(input logic [11:0] lo, input logic [11:0] hi,
                                      input logic [2:0] ctx, input logic [1:0] ien);
      return (64'(hi) << 19) | (64'(lo) << 6) | (64'(ien) << 4) | (64'(ctx) << 1);
   endfunction

   // ctx bit0 supervisor, bit1 user, bit2 hypervisor
   function automatic bit ctx_allows(input logic [2:0] ctx, input int p);
      return (p == 0 && ctx[1]) || (p == 1 && ctx[0]) || (p == 2 && ctx[2]);
   endfunction

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] v;
      logic [11:0] bad [4];
      bad = '{12'h220, 12'h000, 12'hFFF, 12'h209};
      rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
      bus_wdata = '0; priv_level = 2'd0; event_pulse = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 64'h0);
      rd(2'd1, v); chk("R1 counters", v, 64'h0);
      rd(2'd2, v); chk("R1 flags", v, 64'h0);
      chk("R1 irq", 64'(irq), 64'h0);
      pulse('1, 3);
      rd(2'd1, v); chk("R1 no count after reset", v, 64'h0);

      // R3 control layout
      wr(2'd0, '1);
      rd(2'd0, v); chk("R3 writable mask", v, 64'h7FFB_FFFE);
      wr(2'd0, mk(12'hABC, 12'h5A5, 3'b101, 2'b10));
      rd(2'd0, v); chk("R3 field readback", v, mk(12'hABC, 12'h5A5, 3'b101, 2'b10));

      // R2 packed load and readback
      wr(2'd0, 64'h0);
      wr(2'd1, 64'hDEAD_BEEF_0123_4567);
      rd(2'd1, v); chk("R2 packed", v, 64'hDEAD_BEEF_0123_4567);

      // R4 every select pair; line k pulsed k+1 times
      priv_level = 2'd0;
      for (int i = 0; i < NE; i++) begin
         for (int j = 0; j < NE; j++) begin
            wr(2'd0, mk(CODES[i], CODES[j], 3'b010, 2'b00));
            wr(2'd1, 64'h0);
            for (int k = 0; k < NE; k++) pulse(NE'(1) << k, k + 1);
            rd(2'd1, v);
            chk("R4 select sweep", v, {32'(j + 1), 32'(i + 1)});
         end
      end

      // R5 unlisted codes, including the parking code
      for (int b = 0; b < 4; b++) begin
         wr(2'd0, mk(bad[b], bad[3 - b], 3'b111, 2'b00));
         wr(2'd1, 64'h0000_0005_0000_0009);
         for (int p = 0; p < 3; p++) begin
            priv_level = 2'(p);
            pulse('1, 2);
         end
         rd(2'd1, v); chk("R5 unmapped code", v, 64'h0000_0005_0000_0009);
      end

      // R6 / R7 context sweep
      for (int c = 0; c < 8; c++) begin
         for (int p = 0; p < 4; p++) begin
            logic [31:0] e;
            wr(2'd0, mk(CODES[0], CODES[7], 3'(c), 2'b00));
            wr(2'd1, 64'h0);
            priv_level = 2'(p);
            pulse(8'h81, 3);
            e = ctx_allows(3'(c), p) ? 32'd3 : 32'd0;
            rd(2'd1, v);
            if (c == 0) chk("R7 all contexts off", v, {e, e});
            else        chk("R6 context gate", v, {e, e});
         end
      end

      // R8 wrap and sticky flags
      priv_level = 2'd0;
      wr(2'd0, mk(CODES[1], CODES[2], 3'b010, 2'b00));
      wr(2'd1, {32'hFFFF_FFFF, 32'hFFFF_FFFE});
      rd(2'd2, v); chk("R8 flags before wrap", v, 64'h0);
      pulse(8'h06, 1);
      rd(2'd1, v); chk("R8 upper wraps", v, {32'h0, 32'hFFFF_FFFF});
      rd(2'd2, v); chk("R8 upper flag", v, 64'h2);
      chk("R10 irq masked", 64'(irq), 64'h0);
      pulse(8'h02, 1);
      rd(2'd1, v); chk("R8 lower wraps", v, {32'h0, 32'h0});
      rd(2'd2, v); chk("R8 both flags", v, 64'h3);
      pulse(8'h02, 1);
      rd(2'd2, v); chk("R8 flags sticky", v, 64'h3);

      // R10 interrupt enables against flags = 3
      for (int e = 0; e < 4; e++) begin
         wr(2'd0, mk(CODES[1], CODES[2], 3'b000, 2'(e)));
         chk("R10 irq both flags", 64'(irq), 64'(e != 0));
      end

      // R9 write-one-to-clear
      wr(2'd2, 64'h2);
      rd(2'd2, v); chk("R9 clear upper", v, 64'h1);
      for (int e = 0; e < 4; e++) begin
         wr(2'd0, mk(CODES[1], CODES[2], 3'b000, 2'(e)));
         chk("R10 irq lower flag only", 64'(irq), 64'(e[0]));
      end
      wr(2'd2, 64'h0);
      rd(2'd2, v); chk("R9 zero write no effect", v, 64'h1);
      wr(2'd2, 64'h1);
      rd(2'd2, v); chk("R9 clear lower", v, 64'h0);
      chk("R10 irq after clear", 64'(irq), 64'h0);

      // R11 write collides with increment
      wr(2'd0, mk(CODES[3], CODES[3], 3'b010, 2'b11));
      priv_level = 2'd0;
      event_pulse = 8'h08;
      wr(2'd1, {32'h1234_5678, 32'hFFFF_FFFF});
      event_pulse = '0;
      rd(2'd1, v); chk("R11 load beats increment", v, {32'h1234_5678, 32'hFFFF_FFFF});
      rd(2'd2, v); chk("R11 no flag from suppressed step", v, 64'h0);
      chk("R11 irq low", 64'(irq), 64'h0);
      pulse(8'h08, 1);
      rd(2'd1, v); chk("R11 counting resumes", v, {32'h1234_5679, 32'h0});

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule